// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block joins a byte-wide processor bus to one asynchronous serial line in each direction. The processor strobes a write or a read while chip select is high. A control/data line picks which register it reaches. When that line is high, a write goes to the control path and a read returns the status byte. When it is low, a write fills the transmit holding buffer and a read takes the received character.

Control writes come in two phases. After reset, the first control write is a mode word. It fixes the character length, the parity and the stop length, and it sets how many bit-clock enable pulses make one bit time. Each later control write is a command word. A command word can enable the transmitter and receiver, drive the two modem outputs, force a break, clear the error flags, or return the block to waiting for a new mode word. A single `bclk_en_i` pulse input paces both directions.

Top module: `aser_xcvr`

## Requirements
- R1: After reset, `txd_o` is 1, `txempty_o` is 1, `txrdy_o` and `rxrdy_o` are 0, `dtr_o` and `rts_o` are 0, and the status byte reads `{dsr_i,7'b0000101}`. Status bits from bit 0 upward are: holding buffer empty, character waiting, shifter idle, parity error, overrun error, framing error, constant 0, and `dsr_i`.
- R2: After reset or an internal reset, the first control write whose bits 1..0 are not 00 becomes the mode word. A control write with bits 1..0 equal to 00 is ignored in this phase. The mode word does not change until the next internal reset.
- R3: Mode bits 1..0 set the bit time in `bclk_en_i` pulses: 01 gives 1, 10 gives 16 and 11 gives 64. Mode bits 3..2 give 5+value data bits. A transmitted frame is a low start bit, then the data bits LSB first, then the parity bit if enabled, then a high stop period. The line idles high.
- R4: Mode bit 4 enables parity. Mode bit 5 selects even parity when 1 and odd parity when 0. The parity is computed over the character bits only.
- R5: Mode bits 7..6 set the stop period: 01 is one bit time, 10 is one and a half bit times, and 11 is two. The value 00 is treated as one bit time. In the 1-pulse bit-time mode, one and a half rounds up to 2 pulses.
- R6: `txrdy_o` is high when the holding buffer is empty and command bit 0 (transmit enable) is set. A byte in the holding buffer moves into the shifter as soon as the shifter is idle and transmit is enabled. `txempty_o` is high only while the shifter is idle.
- R7: While command bit 3 (break) is set, `txd_o` is held low.
- R8: With command bit 2 (receive enable) set, the receiver behaves as follows:
  - With 16 or 64 pulses per bit, a start bit is confirmed at mid-bit, and each later bit is sampled one bit time apart.
  - With 1 pulse per bit, every pulse takes one bit.
  - A completed character raises `rxrdy_o`, and a data read returns it right-aligned with the unused upper bits 0.
  - A data read lowers `rxrdy_o`.
- R9: A low pulse on `rxd_i` shorter than half a bit time (16 or 64 pulses per bit) starts no character.
- R10: A received parity bit that does not match the parity of the character sets status bit 3. A stop bit sampled low sets status bit 5. Both flags stay set until cleared.
- R11: When a character completes while `rxrdy_o` is still high, status bit 4 is set and the new character replaces the old one.
- R12: Command bit 4 (error reset) clears status bits 3, 4 and 5. It is not stored, and the other command bits of that write still take effect.
- R13: Command bit 6 (internal reset) clears all command bits, empties both transmit registers, stops the receiver and returns the block to waiting for a mode word.
- R14: `dtr_o` follows command bit 1 and `rts_o` follows command bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, qualifies the strobes |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| cd_i | input | 1 | 1: control write / status read, 0: data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (status or received character) |
| bclk_en_i | input | 1 | Bit-clock enable pulse |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| dsr_i | input | 1 | Modem data-set-ready, shown in status bit 7 |
| dtr_o | output | 1 | Modem terminal-ready output |
| rts_o | output | 1 | Modem request-to-send output |
| txrdy_o | output | 1 | Holding buffer may be written |
| rxrdy_o | output | 1 | Received character waiting |
| txempty_o | output | 1 | Transmit shifter idle |

## Verification
The assertions rest on a few assumptions about the inputs.
- A bus access lasts exactly one cycle.
- The mode word is not rewritten while a frame is moving.
- The line is otherwise driven as the frame format describes.

The bench keeps to these assumptions. It issues each access as a single-cycle strobe between falling clock edges, and it changes the mode only through an internal reset while both shifters are idle. It drives `rxd_i` on bit boundaries that it counts from `bclk_en_i` itself. Malformed frames are produced only on purpose: bad parity, a low stop bit and short start glitches.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int BYTE_W = 8;
  localparam int TCNT_W = 8;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       pen;
    logic [1:0] len;
    logic [1:0] fac;
  } mode_t;

  typedef struct packed {
    logic rts;
    logic brk;
    logic rxen;
    logic dtr;
    logic txen;
  } cmd_t;

  function automatic logic [TCNT_W-1:0] bit_ticks(input logic [1:0] fac);
    case (fac)
      2'b10:   return TCNT_W'(16);
      2'b11:   return TCNT_W'(64);
      default: return TCNT_W'(1);
    endcase
  endfunction

  function automatic logic [TCNT_W-1:0] stop_ticks(input mode_t m);
    int halves;
    int t;
    case (m.stop)
      2'b10:   halves = 3;
      2'b11:   halves = 4;
      default: halves = 2;
    endcase
    t = (halves * int'(bit_ticks(m.fac)) + 1) / 2;
    return t[TCNT_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] len);
    return IDX_W'(5) + IDX_W'(len);
  endfunction
endpackage

// File: rtl/aser_regs.sv
module aser_regs
  import aser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ctl_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output mode_t             mode_o,
  output logic              mode_ok_o,
  output cmd_t              cmd_o,
  output logic              err_clr_o,
  output logic              soft_rst_o
);
  mode_t mode_q;
  logic  mode_ok_q;
  cmd_t  cmd_q;
  logic  cmd_wr;

  assign cmd_wr     = we_ctl_i && mode_ok_q;
  assign soft_rst_o = cmd_wr && wdata_i[6];
  assign err_clr_o  = cmd_wr && !wdata_i[6] && wdata_i[4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      mode_ok_q <= 1'b0;
      cmd_q     <= '0;
    end else if (we_ctl_i) begin
      if (!mode_ok_q) begin
        if (wdata_i[1:0] != 2'b00) begin
          mode_q    <= mode_t'(wdata_i);
          mode_ok_q <= 1'b1;
        end
      end else if (wdata_i[6]) begin
        mode_ok_q <= 1'b0;
        cmd_q     <= '0;
      end else begin
        cmd_q <= '{rts: wdata_i[5], brk: wdata_i[3], rxen: wdata_i[2],
                   dtr: wdata_i[1], txen: wdata_i[0]};
      end
    end
  end

  assign mode_o    = mode_q;
  assign mode_ok_o = mode_ok_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/aser_tx.sv
module aser_tx
  import aser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tick_i,
  input  mode_t             mode_i,
  input  logic              txen_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              idle_o
);
  localparam int FRM_W = BYTE_W + 2;

  typedef enum logic [1:0] {TX_IDLE, TX_BITS, TX_STOP} tx_st_e;

  tx_st_e            st_q;
  logic [BYTE_W-1:0] hold_q;
  logic              full_q;
  logic [FRM_W-1:0]  frm_q, frm_n;
  logic [IDX_W-1:0]  left_q, left_n;
  logic [TCNT_W-1:0] tcnt_q;
  logic [IDX_W-1:0]  nb;
  logic [BYTE_W-1:0] dm;
  logic              par, load;
  logic [TCNT_W-1:0] bt, st_len;

  assign bt     = bit_ticks(mode_i.fac);
  assign st_len = stop_ticks(mode_i);
  assign nb     = char_bits(mode_i.len);
  assign load   = (st_q == TX_IDLE) && full_q && txen_i;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) dm[i] = hold_q[i] && (IDX_W'(i) < nb);
    par   = mode_i.even ? ^dm : ~^dm;
    frm_n = '1;
    frm_n[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++) if (IDX_W'(i) < nb) frm_n[i+1] = dm[i];
    if (mode_i.pen) frm_n[nb + IDX_W'(1)] = par;
    left_n = nb + IDX_W'(1) + IDX_W'(mode_i.pen);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      hold_q <= '0;
      full_q <= 1'b0;
      frm_q  <= '1;
      left_q <= '0;
      tcnt_q <= '0;
    end else if (soft_rst_i) begin
      st_q   <= TX_IDLE;
      full_q <= 1'b0;
      frm_q  <= '1;
      tcnt_q <= '0;
    end else begin
      if (load) full_q <= 1'b0;
      if (wr_i) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
      end
      case (st_q)
        TX_IDLE: if (load) begin
          st_q   <= TX_BITS;
          frm_q  <= frm_n;
          left_q <= left_n;
          tcnt_q <= '0;
        end
        TX_BITS: if (tick_i) begin
          if (tcnt_q == bt - TCNT_W'(1)) begin
            tcnt_q <= '0;
            frm_q  <= {1'b1, frm_q[FRM_W-1:1]};
            left_q <= left_q - IDX_W'(1);
            if (left_q == IDX_W'(1)) st_q <= TX_STOP;
          end else begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        TX_STOP: if (tick_i) begin
          if (tcnt_q == st_len - TCNT_W'(1)) begin
            tcnt_q <= '0;
            st_q   <= TX_IDLE;
          end else begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign txd_o        = brk_i ? 1'b0 : ((st_q == TX_BITS) ? frm_q[0] : 1'b1);
  assign hold_empty_o = !full_q;
  assign idle_o       = (st_q == TX_IDLE);
endmodule

// File: rtl/aser_rx.sv
module aser_rx
  import aser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tick_i,
  input  mode_t             mode_i,
  input  logic              rxen_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              rdy_o,
  output logic              pe_o,
  output logic              oe_o,
  output logic              fe_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e            st_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q, data_q;
  logic              parb_q, rdy_q, pe_q, oe_q, fe_q;
  logic [TCNT_W-1:0] bt, half;
  logic [IDX_W-1:0]  nb;
  logic              sample, last, par_exp;

  assign bt      = bit_ticks(mode_i.fac);
  assign half    = bt >> 1;
  assign nb      = char_bits(mode_i.len);
  assign sample  = (st_q == RX_BITS) && tick_i && (tcnt_q == bt - TCNT_W'(1));
  assign last    = sample && (idx_q == nb + IDX_W'(mode_i.pen));
  assign par_exp = mode_i.even ? ^sh_q : ~^sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      parb_q <= 1'b0;
    end else if (soft_rst_i || !rxen_i) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
    end else if (tick_i) begin
      case (st_q)
        RX_IDLE: if (!rxd_i) begin
          tcnt_q <= '0;
          idx_q  <= '0;
          sh_q   <= '0;
          st_q   <= (bt == TCNT_W'(1)) ? RX_BITS : RX_START;
        end
        RX_START: begin
          if (tcnt_q == half - TCNT_W'(1)) begin
            tcnt_q <= '0;
            st_q   <= rxd_i ? RX_IDLE : RX_BITS;
          end else begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        RX_BITS: begin
          if (sample) begin
            tcnt_q <= '0;
            idx_q  <= idx_q + IDX_W'(1);
            if (idx_q < nb) sh_q[idx_q[2:0]] <= rxd_i;
            else if (!last) parb_q <= rxd_i;
            if (last) st_q <= RX_IDLE;
          end else begin
            tcnt_q <= tcnt_q + TCNT_W'(1);
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else if (soft_rst_i) begin
      rdy_q <= 1'b0;
      pe_q  <= 1'b0;
      oe_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      if (rd_i) rdy_q <= 1'b0;
      if (err_clr_i) begin
        pe_q <= 1'b0;
        oe_q <= 1'b0;
        fe_q <= 1'b0;
      end
      if (last && rxen_i) begin
        data_q <= sh_q;
        rdy_q  <= 1'b1;
        if (rdy_q && !rd_i) oe_q <= 1'b1;
        if (!rxd_i) fe_q <= 1'b1;
        if (mode_i.pen && (parb_q != par_exp)) pe_q <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign pe_o   = pe_q;
  assign oe_o   = oe_q;
  assign fe_o   = fe_q;
endmodule

// File: rtl/aser_xcvr.sv
module aser_xcvr
  import aser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              cd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              bclk_en_i,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              dsr_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              txrdy_o,
  output logic              rxrdy_o,
  output logic              txempty_o
);
  mode_t             mode;
  cmd_t              cmd;
  logic              mode_ok, err_clr, soft_rst;
  logic              we_ctl, we_dat, rd_dat;
  logic              hold_empty, tx_idle;
  logic [BYTE_W-1:0] rx_data;
  logic              rx_rdy, rx_pe, rx_oe, rx_fe;
  logic [BYTE_W-1:0] status;

  assign we_ctl = cs_i && wr_i && cd_i;
  assign we_dat = cs_i && wr_i && !cd_i;
  assign rd_dat = cs_i && rd_i && !cd_i;

  aser_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_ctl_i   (we_ctl),
    .wdata_i    (wdata_i),
    .mode_o     (mode),
    .mode_ok_o  (mode_ok),
    .cmd_o      (cmd),
    .err_clr_o  (err_clr),
    .soft_rst_o (soft_rst)
  );

  aser_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst),
    .tick_i       (bclk_en_i),
    .mode_i       (mode),
    .txen_i       (cmd.txen),
    .brk_i        (cmd.brk),
    .wr_i         (we_dat),
    .wdata_i      (wdata_i),
    .txd_o        (txd_o),
    .hold_empty_o (hold_empty),
    .idle_o       (tx_idle)
  );

  aser_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .tick_i     (bclk_en_i),
    .mode_i     (mode),
    .rxen_i     (cmd.rxen),
    .rxd_i      (rxd_i),
    .rd_i       (rd_dat),
    .err_clr_i  (err_clr),
    .data_o     (rx_data),
    .rdy_o      (rx_rdy),
    .pe_o       (rx_pe),
    .oe_o       (rx_oe),
    .fe_o       (rx_fe)
  );

  assign status    = {dsr_i, 1'b0, rx_fe, rx_oe, rx_pe, tx_idle, rx_rdy, hold_empty};
  assign rdata_o   = cd_i ? status : rx_data;
  assign dtr_o     = cmd.dtr;
  assign rts_o     = cmd.rts;
  assign txrdy_o   = hold_empty && cmd.txen;
  assign rxrdy_o   = rx_rdy;
  assign txempty_o = tx_idle;
endmodule

// File: rtl/aser_chk.sv
module aser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txd_o,
  input logic       txempty_o,
  input logic       txrdy_o,
  input logic       rxrdy_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       mode_ok,
  input logic [7:0] mode_bits,
  input logic       brk,
  input logic       txen,
  input logic       oe
);
  a_r7_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk |-> !txd_o);

  a_r3_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txempty_o && !brk) |-> txd_o);

  a_r6_txrdy_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrdy_o |-> txen);

  a_r13_wait_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ok |-> (!dtr_o && !rts_o && !txrdy_o));

  a_r2_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok && $past(mode_ok)) |-> $stable(mode_bits));

  a_r11_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> $past(rxrdy_o));
endmodule

bind aser_xcvr aser_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .txd_o     (txd_o),
  .txempty_o (txempty_o),
  .txrdy_o   (txrdy_o),
  .rxrdy_o   (rxrdy_o),
  .dtr_o     (dtr_o),
  .rts_o     (rts_o),
  .mode_ok   (mode_ok),
  .mode_bits (mode),
  .brk       (cmd.brk),
  .txen      (cmd.txen),
  .oe        (rx_oe)
);

// File: tb/aser_xcvr_tb.sv
`timescale 1ns/1ps
module aser_xcvr_tb;
  logic       clk_i = 0, rst_ni = 0;
  logic       cs_i = 0, wr_i = 0, rd_i = 0, cd_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       bclk_en_i = 0, rxd_i = 1, dsr_i = 0;
  logic       txd_o, dtr_o, rts_o, txrdy_o, rxrdy_o, txempty_o;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [7:0] M8N1 = 8'h4E, M7E1 = 8'h7A, M5O2 = 8'hD2,
                         M6N15 = 8'h87, M8N1X1 = 8'h4D, CMD = 8'h27;

  aser_xcvr u_dut (.*);

  always #4 clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i);
      bclk_en_i = ~bclk_en_i;
    end
  end

  function automatic int fac(input logic [7:0] m);
    case (m[1:0]) 2'b10: return 16; 2'b11: return 64; default: return 1; endcase
  endfunction
  function automatic int nbits(input logic [7:0] m);
    return 5 + int'(m[3:2]);
  endfunction
  function automatic int stopt(input logic [7:0] m);
    int h;
    case (m[7:6]) 2'b10: h = 3; 2'b11: h = 4; default: h = 2; endcase
    return (h * fac(m) + 1) / 2;
  endfunction
  function automatic logic parity(input logic [7:0] m, input logic [7:0] d);
    logic [7:0] x;
    x = d & ((8'd1 << nbits(m)) - 8'd1);
    return m[5] ? ^x : ~^x;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      while (!bclk_en_i) @(posedge clk_i);
    end
  endtask

  task automatic bus_wr(input logic cd, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; cd_i = cd; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic bus_rd(input logic cd, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; cd_i = cd;
    #1 d = rdata_o;
    @(negedge clk_i);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    bus_wr(1, 8'h40);
    bus_wr(1, m);
    bus_wr(1, CMD);
  endtask

  task automatic tx_check(input string tag, input logic [7:0] m,
                          input logic [7:0] d, input bit do_len);
    int f, cnt, guard, exp_len;
    f = fac(m); cnt = 0; guard = 0;
    @(negedge clk_i);
    while (txd_o && guard < 20000) begin @(negedge clk_i); guard++; end
    wait_ticks(f / 2); cnt += f / 2;
    @(negedge clk_i); check({tag, " start"}, txd_o, 0);
    for (int i = 0; i < nbits(m); i++) begin
      wait_ticks(f); cnt += f;
      @(negedge clk_i); check({tag, " data"}, txd_o, d[i]);
    end
    if (m[4]) begin
      wait_ticks(f); cnt += f;
      @(negedge clk_i); check({tag, " R4 parity"}, txd_o, parity(m, d));
    end
    wait_ticks(f); cnt += f;
    @(negedge clk_i); check({tag, " stop"}, txd_o, 1);
    if (do_len) begin
      guard = 0;
      while (!txempty_o && guard < 20000) begin
        @(posedge clk_i); if (bclk_en_i) cnt++;
        guard++;
        @(negedge clk_i);
      end
      exp_len = (1 + nbits(m) + int'(m[4])) * f + stopt(m) - f / 2 + f / 2;
      check({tag, " R5 frame length"},
            ((cnt - exp_len) <= 2 && (exp_len - cnt) <= 2) ? exp_len : cnt, exp_len);
    end
  endtask

  task automatic rx_send(input logic [7:0] m, input logic [7:0] d,
                         input bit bad_par, input bit stop_low);
    int f;
    f = fac(m);
    @(negedge clk_i); rxd_i = 0; wait_ticks(f);
    for (int i = 0; i < nbits(m); i++) begin
      @(negedge clk_i); rxd_i = d[i]; wait_ticks(f);
    end
    if (m[4]) begin
      @(negedge clk_i); rxd_i = parity(m, d) ^ bad_par; wait_ticks(f);
    end
    @(negedge clk_i);
    if (stop_low) begin
      rxd_i = 0; wait_ticks(f / 2 + 2);
      @(negedge clk_i);
    end
    rxd_i = 1; wait_ticks(2 * f);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d, d2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    bus_rd(1, r);
    check("R1 status", r, 8'h05);
    check("R1 txd", txd_o, 1);
    check("R1 flags", {txrdy_o, rxrdy_o, txempty_o, dtr_o, rts_o}, 5'b00100);

    // R2: factor 00 ignored, then mode, then command
    bus_wr(1, 8'h00);
    bus_wr(1, M8N1);
    bus_wr(1, CMD);
    check("R2 R14 modem outputs from command", {dtr_o, rts_o}, 2'b11);
    check("R6 txrdy enabled", txrdy_o, 1);
    dsr_i = 1;
    bus_rd(1, r);
    check("R14 dsr in status", r[7], 1);
    dsr_i = 0;

    // R6: holding buffer then shifter
    d = 8'($urandom); d2 = 8'($urandom);
    bus_wr(0, d);
    // bus_wr returns at the negedge right after the write edge: buffer full
    check("R6 txrdy low after write", txrdy_o, 0);
    @(negedge clk_i);
    check("R6 moved to shifter", {txrdy_o, txempty_o}, 2'b10);
    bus_wr(0, d2);
    check("R6 holding full while shifting", txrdy_o, 0);
    tx_check("R3 8N1 first", M8N1, d, 0);
    tx_check("R3 8N1 second", M8N1, d2, 1);

    for (int n = 0; n < 3; n++) begin
      d = 8'($urandom);
      bus_wr(0, d);
      tx_check("R3 8N1 random", M8N1, d, 1);
    end

    // R13: internal reset
    bus_wr(1, 8'h40);
    check("R13 command cleared", {dtr_o, rts_o, txrdy_o}, 3'b000);
    bus_wr(1, M7E1);
    bus_wr(1, CMD);
    check("R13 R2 new mode accepted then command", {dtr_o, rts_o}, 2'b11);
    for (int n = 0; n < 2; n++) begin
      d = 8'($urandom);
      bus_wr(0, d);
      tx_check("R4 7E1", M7E1, d, 1);
    end
    set_mode(M5O2);
    d = 8'($urandom);
    bus_wr(0, d);
    tx_check("R5 5O2", M5O2, d, 1);
    set_mode(M6N15);
    d = 8'($urandom);
    bus_wr(0, d);
    tx_check("R5 6N1.5 x64", M6N15, d, 1);

    // R7 break
    set_mode(M8N1);
    bus_wr(1, CMD | 8'h08);
    check("R7 break low", txd_o, 0);
    bus_wr(1, CMD);
    check("R7 break released", txd_o, 1);

    // R8 receive
    for (int n = 0; n < 3; n++) begin
      d = 8'($urandom);
      rx_send(M8N1, d, 0, 0);
      check("R8 rxrdy", rxrdy_o, 1);
      bus_rd(0, r);
      check("R8 rx data", r, d);
      check("R8 rxrdy cleared by read", rxrdy_o, 0);
    end

    // R9 glitch
    @(negedge clk_i); rxd_i = 0; wait_ticks(3);
    @(negedge clk_i); rxd_i = 1; wait_ticks(40);
    check("R9 glitch ignored", rxrdy_o, 0);
    d = 8'hA5;
    rx_send(M8N1, d, 0, 0);
    bus_rd(0, r);
    check("R9 frame after glitch", r, d);

    // R11 overrun
    rx_send(M8N1, 8'h11, 0, 0);
    rx_send(M8N1, 8'h22, 0, 0);
    bus_rd(1, r);
    check("R11 overrun flag", r[5:3], 3'b010);
    bus_rd(0, r);
    check("R11 newer char kept", r, 8'h22);

    // R12 error reset
    bus_wr(1, CMD | 8'h10);
    bus_rd(1, r);
    check("R12 errors cleared", r[5:3], 3'b000);
    check("R12 command kept", {dtr_o, rts_o}, 2'b11);

    // R10 framing and parity
    rx_send(M8N1, 8'h3C, 0, 1);
    bus_rd(1, r);
    check("R10 framing error", r[5:3], 3'b100);
    bus_rd(0, r);
    bus_wr(1, CMD | 8'h10);
    set_mode(M7E1);
    rx_send(M7E1, 8'h55, 1, 0);
    bus_rd(1, r);
    check("R10 parity error", r[5:3], 3'b001);
    bus_rd(0, r);
    check("R8 7-bit right aligned", r, 8'h55);
    rx_send(M7E1, 8'hFF, 0, 0);
    bus_rd(0, r);
    check("R8 R4 upper bits zero", r, 8'h7F);

    // R8 x1 receive
    set_mode(M8N1X1);
    d = 8'($urandom);
    rx_send(M8N1X1, d, 0, 0);
    bus_rd(0, r);
    check("R8 x1 rx data", r, d);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule